// File: doc/BRIEF.md
# Grouped Interrupt Combiner

The combiner collects level-sensitive interrupt lines from peripherals and merges them into a few combined requests for a main interrupt controller. The lines are split into groups of eight. Four groups share one 32-bit word, and group n occupies byte lane n of every register. Each group drives its own combined request. Each group also reports the index of its lowest-numbered line that is both pending and enabled, so a handler can go straight to that source.

Software masks and unmasks lines through two separate write ports. One port sets enable bits and the other clears them. Each port acts only on the bits written as one, so no read-modify-write is needed. A third offset returns the masked status word. The input lines are captured in a register on every clock. All results derive from that captured copy and from the enable word.

There is no sequencing in this block. It is a register bank with combinational reduction behind it, so no state machine appears.

Top module: `intr_combiner_top`

## Requirements
- R1: After reset every enable bit is zero, the status word reads zero, and every group's request and valid flag are low.
- R2: A write at offset 0x0 sets each enable bit whose data bit is one and leaves all other enable bits unchanged.
- R3: A write at offset 0x4 clears each enable bit whose data bit is one and leaves all other enable bits unchanged.
- R4: A read at offset 0x0 or offset 0x4 returns the current enable word.
- R5: A read at offset 0xC returns the captured input lines ANDed with the enable word. The captured lines are the values present at the previous rising clock edge.
- R6: The request output of group n (bit n) is the OR of bits [8n+7:8n] of the status word.
- R7: The index field of group n occupies bits [3n+2:3n]. Whenever the group has any status bit set, this field holds the position (0 to 7) of the lowest set status bit in that byte, and the group's valid flag is high.
- R8: When no status bit of a group is set, the valid flag of that group is low and its index field is zero.
- R9: A read at any offset other than 0x0, 0x4 or 0xC returns zero. A write to offset 0xC or to any other unused offset leaves the enable word unchanged.
- R10: Lines are level-sensitive. A status bit stays set for as long as its input is held high and its enable bit is set. It drops one clock edge after the input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 32 | Level-sensitive interrupt lines; line 8n+k is line k of group n |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 4 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| grp_irq | output | 4 | Combined request for each group |
| grp_idx | output | 12 | Lowest pending enabled index, 3 bits per group |
| grp_vld | output | 4 | Index valid for each group |

## Verification
A write to the set or clear port takes effect at the rising edge that samples it. A change on an input line is captured at the next rising edge. Read data and the group outputs are combinational from those two registers, so every result is due one edge after its stimulus. The bench drives inputs on the falling edge. It lets exactly one rising edge pass and then samples at the following falling edge, or 1 ns after placing a read address. For the level test it samples once after the edge that captures the falling input. That confirms the drop happens after one edge and no later.

// File: rtl/intr_combiner_pkg.sv
package intr_combiner_pkg;
    localparam int unsigned ADDR_W   = 4;
    localparam logic [ADDR_W-1:0] OFS_EN_SET = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 4'hC;
endpackage

// File: rtl/cmb_enable_bank.sv
module cmb_enable_bank #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_stb,
    input  logic              clr_stb,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] enable
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable <= '0;
        end else if (set_stb) begin
            enable <= enable | wdata;
        end else if (clr_stb) begin
            enable <= enable & ~wdata;
        end
    end

    // R2: every bit written as one is set afterwards
    a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((enable & $past(wdata)) == $past(wdata)));
    // R2: bits written as zero keep their value
    a_r2_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((enable & ~$past(wdata)) == ($past(enable) & ~$past(wdata))));
    // R3: every bit written as one is clear afterwards
    a_r3_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !set_stb) |=> ((enable & $past(wdata)) == '0));
endmodule

// File: rtl/cmb_group.sv
module cmb_group #(
    parameter int unsigned LINES = 8,
    localparam int unsigned IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] bits,
    output logic             out_irq,
    output logic [IDX_W-1:0] out_idx,
    output logic             out_vld
);
    always_comb begin
        out_idx = '0;
        out_vld = 1'b0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (bits[i]) begin
                out_idx = IDX_W'(i);
                out_vld = 1'b1;
            end
        end
    end

    assign out_irq = |bits;

    // R6: request and encoder valid agree
    a_r6_req_matches: assert property (@(posedge clk) disable iff (!rst_n)
        out_irq == out_vld);
    // R7: reported index is pending and nothing lower is
    a_r7_idx_pending: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> bits[out_idx]);
    a_r7_idx_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ((bits & ((LINES'(1) << out_idx) - LINES'(1))) == '0));
    // R8: invalid means nothing pending and index zero
    a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (bits == '0 && out_idx == '0));
endmodule

// File: rtl/intr_combiner_top.sv
module intr_combiner_top
    import intr_combiner_pkg::*;
#(
    parameter int unsigned GROUPS = 4,
    parameter int unsigned LINES  = 8,
    localparam int unsigned WORD_W = GROUPS * LINES,
    localparam int unsigned IDX_W  = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [WORD_W-1:0]       irq_in,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [WORD_W-1:0]       bus_wdata,
    output logic [WORD_W-1:0]       bus_rdata,
    output logic [GROUPS-1:0]       grp_irq,
    output logic [GROUPS*IDX_W-1:0] grp_idx,
    output logic [GROUPS-1:0]       grp_vld
);
    logic [WORD_W-1:0] enable;
    logic [WORD_W-1:0] line_q;
    logic [WORD_W-1:0] status;
    logic              set_stb;
    logic              clr_stb;

    assign set_stb = bus_wr && (bus_addr == OFS_EN_SET);
    assign clr_stb = bus_wr && (bus_addr == OFS_EN_CLR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= irq_in;
    end

    cmb_enable_bank #(.WORD_W(WORD_W)) u_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (set_stb),
        .clr_stb (clr_stb),
        .wdata   (bus_wdata),
        .enable  (enable)
    );

    assign status = line_q & enable;

    always_comb begin
        unique case (bus_addr)
            OFS_EN_SET, OFS_EN_CLR: bus_rdata = enable;
            OFS_STATUS:             bus_rdata = status;
            default:                bus_rdata = '0;
        endcase
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        cmb_group #(.LINES(LINES)) u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .bits    (status[g*LINES +: LINES]),
            .out_irq (grp_irq[g]),
            .out_idx (grp_idx[g*IDX_W +: IDX_W]),
            .out_vld (grp_vld[g])
        );
    end

    // R9: writes to unused or status offsets do not touch enables
    a_r9_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !set_stb && !clr_stb) |=> $stable(enable));
    // R10: a line that fell is no longer pending after one edge
    a_r10_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in == '0) |=> (status == '0));
endmodule

// File: tb/intr_combiner_top_tb.sv
module intr_combiner_top_tb;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  irq_in = '0;
    logic          bus_wr = 1'b0;
    logic [3:0]    bus_addr = 4'h0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [3:0]    grp_irq;
    logic [11:0]   grp_idx;
    logic [3:0]    grp_vld;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    intr_combiner_top u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .grp_irq(grp_irq), .grp_idx(grp_idx), .grp_vld(grp_vld)
    );

    typedef struct packed {
        logic [W-1:0] lines;
        logic [W-1:0] set_w;
        logic [W-1:0] clr_w;
        logic [W-1:0] exp_stat;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{32'hFFFFFFFF, 32'h00000001, 32'h00000000, 32'h00000001},
        '{32'h0F0F0F0F, 32'hFFFFFFFF, 32'h00FF0000, 32'h0F000F0F},
        '{32'h80402010, 32'hF0F0F0F0, 32'h00000000, 32'h80402010},
        '{32'hA5A5A5A5, 32'h0000FFFF, 32'h00005A00, 32'h0000A5A5},
        '{32'h12345678, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000}
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [11:0] model_idx(input logic [W-1:0] s);
        logic [11:0] r = '0;
        for (int g = 0; g < 4; g++) begin
            for (int b = 7; b >= 0; b--) begin
                if (s[g*8+b]) r[g*3 +: 3] = 3'(b);
            end
        end
        return r;
    endfunction

    function automatic logic [3:0] model_any(input logic [W-1:0] s);
        logic [3:0] r;
        for (int g = 0; g < 4; g++) r[g] = |s[g*8 +: 8];
        return r;
    endfunction

    task automatic check_groups(input string tag, input logic [W-1:0] s);
        check({tag, " R6 grp_irq"}, W'(grp_irq), W'(model_any(s)));
        check({tag, " R7 grp_idx"}, W'(grp_idx), W'(model_idx(s)));
        check({tag, " R8 grp_vld"}, W'(grp_vld), W'(model_any(s)));
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] rd;
        logic [W-1:0] en_exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(4'h0, rd); check("R1 enable", rd, '0);
        bus_read(4'hC, rd); check("R1 status", rd, '0);
        check_groups("R1", '0);

        // vector table: R2 R3 R4 R5
        foreach (VECS[i]) begin
            bus_write(4'h4, 32'hFFFFFFFF);
            irq_in = VECS[i].lines;
            bus_write(4'h0, VECS[i].set_w);
            bus_write(4'h4, VECS[i].clr_w);
            en_exp = VECS[i].set_w & ~VECS[i].clr_w;
            bus_read(4'h0, rd); check("R2 R4 read enable at 0x0", rd, en_exp);
            bus_read(4'h4, rd); check("R3 R4 read enable at 0x4", rd, en_exp);
            bus_read(4'hC, rd); check("R5 status", rd, VECS[i].exp_stat);
            check_groups("R5 vec", VECS[i].exp_stat);
        end

        // R2 set keeps other bits; R3 clear keeps other bits
        bus_write(4'h4, 32'hFFFFFFFF);
        bus_write(4'h0, 32'h0000000F);
        bus_write(4'h0, 32'hF0000000);
        bus_read(4'h0, rd); check("R2 accumulate", rd, 32'hF000000F);
        bus_write(4'h4, 32'h10000001);
        bus_read(4'h0, rd); check("R3 partial clear", rd, 32'hE000000E);

        // R9 writes to 0xC and 0x8 ignored, reads of 0x8 return zero
        bus_write(4'hC, 32'hFFFFFFFF);
        bus_read(4'h0, rd); check("R9 write to 0xC", rd, 32'hE000000E);
        bus_write(4'h8, 32'h00000000);
        bus_write(4'h8, 32'hFFFFFFFF);
        bus_read(4'h0, rd); check("R9 write to 0x8", rd, 32'hE000000E);
        irq_in = 32'hFFFFFFFF;
        @(negedge clk);
        bus_read(4'h8, rd); check("R9 read 0x8", rd, '0);
        bus_read(4'h1, rd); check("R9 read 0x1", rd, '0);

        // R7 priority corners in group 2
        bus_write(4'h4, 32'hFFFFFFFF);
        bus_write(4'h0, 32'h00FF0000);
        irq_in = 32'h00FF0000;
        @(negedge clk);
        check_groups("R7 all eight", 32'h00FF0000);
        irq_in = 32'h00800000;
        @(negedge clk);
        check_groups("R7 only bit7", 32'h00800000);

        // R10 level held, then dropped after one edge
        repeat (3) @(negedge clk);
        bus_read(4'hC, rd); check("R10 held", rd, 32'h00800000);
        irq_in = '0;
        @(negedge clk);
        bus_read(4'hC, rd); check("R10 dropped", rd, '0);
        check_groups("R10 R8 idle", '0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule